// File: doc/BRIEF.md
# Benes Layer Switch-State and Subtable Builder

This block finishes the routing of one layer of a rearrangeable Benes network. It receives a list of input/output port pairs that an upstream sorter has already put in order: each pair in an even slot of the list must pass through the upper half-size subnetwork, and each pair in an odd slot through the lower one. From this list the block works out the setting, cross or bar, of every input-side and output-side 2x2 switch in the layer. It also builds the two forward routing tables that the next, half-size layer needs.

Operation starts with a one-cycle `start` strobe while the block is idle. The list is copied into internal registers on that edge. The block then walks the even slots, one per clock. In each step it reads one even-slot pair and the odd-slot pair that follows it. The even pair sets one input switch and one output switch, and writes one entry of the upper table. The odd pair writes one entry of the lower table. Because every table entry is written at the position given by its own halved input port, both tables come out in ascending input order with no extra sort pass. After the last step, a one-cycle `done` marks the results as valid. The results then hold until the next run.

Top module: `benes_layer_setter`

## Requirements
- R1: After reset, `busy` and `done` are low and all four result outputs are zero.
- R2: A `start` sampled high while idle captures `listIn` and `listOut`. `busy` is high from the next cycle. `done` is high for exactly one cycle, NUM_PORTS/2 clock edges after the capturing edge, and `busy` falls at the same edge.
- R3: For each even slot 2m holding input port p, bit p>>1 of `inSwitch` becomes bit 0 of p: 1 means cross (p odd) and 0 means bar (p even).
- R4: For each even slot 2m holding output port q, bit q>>1 of `outSwitch` becomes bit 0 of q, with the same encoding of cross = 1 and bar = 0.
- R5: For each even-slot pair (p, q), entry p>>1 of `upperTable` (bits [(p>>1)*SW +: SW], with SW = log2(NUM_PORTS)-1) holds q>>1.
- R6: For each odd-slot pair (p, q), entry p>>1 of `lowerTable` holds q>>1, in the same field layout as R5.
- R7: A `start` raised while `busy` is high is ignored. The run in progress completes on its original schedule, and its results come from the list captured at its own start.
- R8: While the block is idle, the result outputs do not change, even if the list inputs change.
- R9: For the 8-port sorted list (0,0),(1,2),(5,3),(4,1),(2,4),(3,6),(6,7),(7,5), the input switches 0..3 are bar, bar, cross, bar. The output switches 0..3 are bar, cross, bar, cross. The upper table is 0,2,1,3 and the lower table is 1,3,0,2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; acted on only while idle |
| listIn | input | NUM_PORTS*log2(NUM_PORTS) | Input port of each sorted slot; slot k at bits [k*W +: W] |
| listOut | input | NUM_PORTS*log2(NUM_PORTS) | Output port of each sorted slot, same layout |
| inSwitch | output | NUM_PORTS/2 | Input switch states, bit j is switch j, 1 = cross |
| outSwitch | output | NUM_PORTS/2 | Output switch states, bit j is switch j, 1 = cross |
| upperTable | output | NUM_PORTS/2*(log2(NUM_PORTS)-1) | Upper subnetwork table, entry j is the output for input j |
| lowerTable | output | NUM_PORTS/2*(log2(NUM_PORTS)-1) | Lower subnetwork table, same layout |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe: results are complete |

## Verification
The checker checks the run protocol on every cycle:
- `done` is a single-cycle strobe that arrives only at the end of a busy period.
- The busy period always lasts NUM_PORTS/2 cycles.
- `busy` begins only after a `start`.
- The results never move while the block is idle.

The values themselves can only be shown by the bench's scenarios: the switch states, the table entries and their placement in ascending order. These scenarios cover the worked 8-port list, an all-bar identity list and an all-cross reversing list. A further scenario shows that a `start` arriving mid-run leaves the captured list untouched.

// File: rtl/benes_layer_pkg.sv
package benes_layer_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // copy the incoming list into the slot registers
    logic advance;   // process the current even/odd slot pair
    logic finish;    // this advance is the final one
  } layerStrobe_t;

endpackage

// File: rtl/benes_layer_ctrl.sv
module benes_layer_ctrl
  import benes_layer_pkg::*;
#(
  parameter int HALF  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output layerStrobe_t     strobe,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && start;
    strobe.advance = (state == ST_RUN);
    strobe.finish  = (state == ST_RUN) && (stepIdx == LAST_IDX);
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.capture) begin
        state   <= ST_RUN;
        stepIdx <= '0;
      end else if (strobe.advance) begin
        if (strobe.finish) begin
          state   <= ST_IDLE;
          stepIdx <= '0;
        end else begin
          stepIdx <= stepIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/benes_layer_datapath.sv
module benes_layer_datapath
  import benes_layer_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3,
  parameter int SUB_W     = 2,
  parameter int HALF      = 4,
  parameter int IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  layerStrobe_t                strobe,
  input  logic [IDX_W-1:0]            stepIdx,
  input  logic [NUM_PORTS*PORT_W-1:0] listInFlat,
  input  logic [NUM_PORTS*PORT_W-1:0] listOutFlat,
  output logic [HALF-1:0]             inSwitch,
  output logic [HALF-1:0]             outSwitch,
  output logic [HALF*SUB_W-1:0]       upperFlat,
  output logic [HALF*SUB_W-1:0]       lowerFlat
);

  logic [PORT_W-1:0] newIn   [NUM_PORTS];
  logic [PORT_W-1:0] newOut  [NUM_PORTS];
  logic [PORT_W-1:0] slotIn  [NUM_PORTS];
  logic [PORT_W-1:0] slotOut [NUM_PORTS];
  logic [SUB_W-1:0]  upperTab [HALF];
  logic [SUB_W-1:0]  lowerTab [HALF];
  logic [HALF-1:0]   inSwReg;
  logic [HALF-1:0]   outSwReg;

  // Unpack the flat list ports
  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_unpack
    assign newIn[k]  = listInFlat[k*PORT_W +: PORT_W];
    assign newOut[k] = listOutFlat[k*PORT_W +: PORT_W];
  end

  // Capture the sorted list
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PORTS; k++) begin
        slotIn[k]  <= '0;
        slotOut[k] <= '0;
      end
    end else if (strobe.capture) begin
      for (int k = 0; k < NUM_PORTS; k++) begin
        slotIn[k]  <= newIn[k];
        slotOut[k] <= newOut[k];
      end
    end
  end

  // Current even slot and its odd partner
  logic [PORT_W-1:0] evenIn, evenOut, oddIn, oddOut;
  logic [PORT_W-1:0] evenPos, oddPos;

  always_comb begin
    evenPos = {stepIdx, 1'b0};
    oddPos  = {stepIdx, 1'b1};
    evenIn  = slotIn[evenPos];
    evenOut = slotOut[evenPos];
    oddIn   = slotIn[oddPos];
    oddOut  = slotOut[oddPos];
  end

  // Switch state: the port's low bit says whether it is the second port of its switch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inSwReg  <= '0;
      outSwReg <= '0;
    end else if (strobe.advance) begin
      inSwReg[evenIn[PORT_W-1:1]]   <= evenIn[0];
      outSwReg[evenOut[PORT_W-1:1]] <= evenOut[0];
    end
  end

  // Half-size tables, each indexed by the halved input port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < HALF; j++) begin
        upperTab[j] <= '0;
        lowerTab[j] <= '0;
      end
    end else if (strobe.advance) begin
      upperTab[evenIn[PORT_W-1:1]] <= evenOut[PORT_W-1:1];
      lowerTab[oddIn[PORT_W-1:1]]  <= oddOut[PORT_W-1:1];
    end
  end

  assign inSwitch  = inSwReg;
  assign outSwitch = outSwReg;

  for (genvar j = 0; j < HALF; j++) begin : g_pack
    assign upperFlat[j*SUB_W +: SUB_W] = upperTab[j];
    assign lowerFlat[j*SUB_W +: SUB_W] = lowerTab[j];
  end

endmodule

// File: rtl/benes_layer_setter.sv
module benes_layer_setter
  import benes_layer_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int SUB_W  = PORT_W - 1,
  localparam int HALF   = NUM_PORTS / 2,
  localparam int IDX_W  = $clog2(HALF)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_PORTS*PORT_W-1:0] listIn,
  input  logic [NUM_PORTS*PORT_W-1:0] listOut,
  output logic [HALF-1:0]             inSwitch,
  output logic [HALF-1:0]             outSwitch,
  output logic [HALF*SUB_W-1:0]       upperTable,
  output logic [HALF*SUB_W-1:0]       lowerTable,
  output logic                        busy,
  output logic                        done
);

  layerStrobe_t     strobe;
  logic [IDX_W-1:0] stepIdx;

  benes_layer_ctrl #(
    .HALF (HALF),
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strobe (strobe),
    .stepIdx(stepIdx),
    .busy   (busy),
    .done   (done)
  );

  benes_layer_datapath #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_W   (PORT_W),
    .SUB_W    (SUB_W),
    .HALF     (HALF),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .stepIdx    (stepIdx),
    .listInFlat (listIn),
    .listOutFlat(listOut),
    .inSwitch   (inSwitch),
    .outSwitch  (outSwitch),
    .upperFlat  (upperTable),
    .lowerFlat  (lowerTable)
  );

endmodule

// File: rtl/benes_layer_setter_chk.sv
module benes_layer_setter_chk #(
  parameter int NUM_PORTS = 8,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int SUB_W  = PORT_W - 1,
  localparam int HALF   = NUM_PORTS / 2,
  localparam int CNT_W  = $clog2(HALF) + 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [HALF-1:0]       inSwitch,
  input logic [HALF-1:0]       outSwitch,
  input logic [HALF*SUB_W-1:0] upperTable,
  input logic [HALF*SUB_W-1:0] lowerTable
);

  // Busy-edge counter for the run length check
  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busyCnt == CNT_W'(HALF)));

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(inSwitch) && $stable(outSwitch)
               && $stable(upperTable) && $stable(lowerTable)));

endmodule

bind benes_layer_setter benes_layer_setter_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .inSwitch  (inSwitch),
  .outSwitch (outSwitch),
  .upperTable(upperTable),
  .lowerTable(lowerTable)
);

// File: tb/benes_layer_setter_test.sv
module benes_layer_setter_test;

  localparam int N    = 8;
  localparam int W    = $clog2(N);
  localparam int SW   = W - 1;
  localparam int HALF = N / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [N*W-1:0]    listIn = '0;
  logic [N*W-1:0]    listOut = '0;
  logic [HALF-1:0]   inSwitch, outSwitch;
  logic [HALF*SW-1:0] upperTable, lowerTable;
  logic              busy, done;

  int total = 0;
  int bad   = 0;

  int curIn  [N];
  int curOut [N];
  logic [HALF-1:0]    expIn, expOut;
  logic [HALF*SW-1:0] expUp, expLo;

  always #4 clk = ~clk;  // 125 MHz

  benes_layer_setter #(.NUM_PORTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .listIn(listIn), .listOut(listOut),
    .inSwitch(inSwitch), .outSwitch(outSwitch),
    .upperTable(upperTable), .lowerTable(lowerTable),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Expected results derived from R3..R6
  task automatic buildExpected();
    expIn = '0; expOut = '0; expUp = '0; expLo = '0;
    for (int m = 0; m < HALF; m++) begin
      int pe = curIn[2*m];
      int qe = curOut[2*m];
      int po = curIn[2*m+1];
      int qo = curOut[2*m+1];
      expIn[pe/2]            = pe[0];
      expOut[qe/2]           = qe[0];
      expUp[(pe/2)*SW +: SW] = SW'(qe/2);
      expLo[(po/2)*SW +: SW] = SW'(qo/2);
    end
  endtask

  task automatic packList();
    for (int k = 0; k < N; k++) begin
      listIn[k*W +: W]  = W'(curIn[k]);
      listOut[k*W +: W] = W'(curOut[k]);
    end
  endtask

  // Pulse start, then count cycles until done (R2)
  task automatic launchAndWait(input string tag);
    int cyc = 0;
    @(negedge clk);
    packList();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", {tag, " busy after start"}, 64'(busy), 64'd1);
    while (!done && cyc < 4*HALF) begin
      @(negedge clk);
      cyc++;
    end
    check("R2", {tag, " cycles to done"}, 64'(cyc), 64'(HALF));
    check("R2", {tag, " busy low at done"}, 64'(busy), 64'd0);
    @(negedge clk);
    check("R2", {tag, " done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic compareResults(input string tag);
    check("R3", {tag, " inSwitch"},   64'(inSwitch),   64'(expIn));
    check("R4", {tag, " outSwitch"},  64'(outSwitch),  64'(expOut));
    check("R5", {tag, " upperTable"}, 64'(upperTable), 64'(expUp));
    check("R6", {tag, " lowerTable"}, 64'(lowerTable), 64'(expLo));
  endtask

  task automatic testReset();
    check("R1", "busy",       64'(busy),       64'd0);
    check("R1", "done",       64'(done),       64'd0);
    check("R1", "inSwitch",   64'(inSwitch),   64'd0);
    check("R1", "outSwitch",  64'(outSwitch),  64'd0);
    check("R1", "upperTable", 64'(upperTable), 64'd0);
    check("R1", "lowerTable", 64'(lowerTable), 64'd0);
  endtask

  task automatic loadExample();
    curIn  = '{0, 1, 5, 4, 2, 3, 6, 7};
    curOut = '{0, 2, 3, 1, 4, 6, 7, 5};
  endtask

  task automatic testExample();
    loadExample();
    buildExpected();
    launchAndWait("example");
    compareResults("example");
    // R9: fixed values, independent of the model
    check("R9", "input switches",  64'(inSwitch),  64'b0100);
    check("R9", "output switches", 64'(outSwitch), 64'b1010);
    check("R9", "upper table", 64'(upperTable), {56'd0, 2'd3, 2'd1, 2'd2, 2'd0});
    check("R9", "lower table", 64'(lowerTable), {56'd0, 2'd2, 2'd0, 2'd3, 2'd1});
  endtask

  task automatic testIdentity();
    for (int k = 0; k < N; k++) begin
      curIn[k] = k;
      curOut[k] = k;
    end
    buildExpected();
    launchAndWait("identity");
    compareResults("identity");
  endtask

  task automatic testAllCross();
    for (int k = 0; k < N; k++) begin
      curIn[k] = k ^ 1;
      curOut[k] = N - 1 - k;
    end
    buildExpected();
    launchAndWait("all-cross");
    compareResults("all-cross");
  endtask

  // R7: start during busy must not recapture the list
  task automatic testStartWhileBusy();
    int cyc = 1;
    loadExample();
    buildExpected();
    @(negedge clk);
    packList();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < N; k++) begin
      curIn[k] = k;
      curOut[k] = k;
    end
    packList();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 4*HALF) begin
      @(negedge clk);
      cyc++;
    end
    check("R7", "schedule unchanged", 64'(cyc), 64'(HALF));
    check("R7", "inSwitch from first list",   64'(inSwitch),   64'(expIn));
    check("R7", "upperTable from first list", 64'(upperTable), 64'(expUp));
    check("R7", "lowerTable from first list", 64'(lowerTable), 64'(expLo));
    @(negedge clk);
    check("R7", "idle after run", 64'(busy), 64'd0);
  endtask

  // R8: inputs change while idle, results stay put
  task automatic testHoldIdle();
    for (int k = 0; k < N; k++) begin
      curIn[k] = (k * 3) % N;
      curOut[k] = (k * 5) % N;
    end
    packList();
    repeat (6) @(negedge clk);
    check("R8", "inSwitch held",   64'(inSwitch),   64'(expIn));
    check("R8", "outSwitch held",  64'(outSwitch),  64'(expOut));
    check("R8", "upperTable held", 64'(upperTable), 64'(expUp));
    check("R8", "lowerTable held", 64'(lowerTable), 64'(expLo));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R2 watchdog expired: actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testExample();
    testIdentity();
    testAllCross();
    testStartWhileBusy();
    testHoldIdle();
    summary();
  end

endmodule